// File: doc/BRIEF.md
# Power-Fail and Pushbutton Reset Supervisor

This block decides when the rest of the chip is held in reset and when register access is blocked. It has two sources. The first is a digital out-of-tolerance flag from an external supply comparator. The second is a bidirectional open-drain reset pin. The block pulls that pin low itself, and it also reads the pin back so that a pushbutton wired to it can be detected.

While the supply is bad, the pin is pulled low and access is blocked. When the supply recovers, both stay asserted for a fixed settling time. That time is lengthened by an oscillator startup period if the oscillator had been switched off during backup.

When no reset cycle is running, a falling edge on the pin counts as a button press. The press starts a debounce sequence with three phases: a timed pull-down, then a wait for the button to be released if it is still held, then a second timed pull-down once the release is seen. A power failure at any point abandons the pushbutton sequence.

Top module: `pwr_pb_reset_sup`

## Requirements
- R1: While `rst_n` is low, the block is in the power-fail state, with `pin_pd_o` = 1 and `inhibit_o` = 1.
- R2: When `pwr_fail_i` = 1 is sampled on a rising clock edge, `pin_pd_o` and `inhibit_o` are both 1 after that edge, whatever the block was doing.
- R3: Let edge k be the first edge that samples `pwr_fail_i` = 0 with `osc_off_i` = 0. Both outputs stay 1 up to and including edge k+T_RST-1, and both drop after edge k+T_RST.
- R4: If `osc_off_i` = 1 at edge k, both outputs drop after edge k+T_RST+T_OSC instead. The value of `osc_off_i` is taken at edge k only.
- R5: In the idle state, a pin value of 0 first sampled at edge k (after the pin was 1) sets both outputs to 1 after edge k+2. `pin_pd_o` then stays 1 for exactly T_PBDB cycles.
- R6: Falling edges on the pin that occur while a power-fail hold is running start no pushbutton sequence. This holds even if the pin stays low after the hold ends: the outputs drop on the R3 schedule and stay 0.
- R7: If the pin reads 1 when the first pull-down ends after edge e, `pin_pd_o` drops after edge e, `inhibit_o` drops after edge e+3, and the block returns to idle.
- R8: If the pin still reads 0 after the first pull-down, `inhibit_o` stays 1 with `pin_pd_o` at 0 until the pin returns to 1. For a pin value of 1 first sampled at edge r, `pin_pd_o` is 1 after edge r+2 for T_PBDB cycles. Then both outputs drop together.
- R9: A power failure during any pushbutton phase aborts the sequence. The outputs then follow R2 and R3, with no leftover pushbutton timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_fail_i | input | 1 | Supply out-of-tolerance flag, synchronous, 1 = bad |
| osc_off_i | input | 1 | 1 = oscillator was disabled in backup; lengthens the recovery hold |
| pin_i | input | 1 | Sampled level of the open-drain reset pin |
| pin_pd_o | output | 1 | 1 = pull the reset pin low |
| inhibit_o | output | 1 | 1 = block register read/write access |

## Verification
The pin path has two synchronizer flops before the state register, so a press affects the outputs two edges after the pin is first sampled low, and a release does the same. The supply path has no extra stage: the outputs react one edge after the flag changes, and the recovery hold ends T_RST (or T_RST+T_OSC) edges later. After the first pull-down, the release of `inhibit_o` trails `pin_pd_o` by three edges, because the synchronizer must settle before the pin is read. The bench changes inputs just after a falling clock edge and counts whole cycles to each of these points. It samples on falling edges one cycle before and one cycle after each expected transition, so that both an early and a late change are caught.

// File: rtl/pwr_pb_reset_sup.sv
module pwr_pb_reset_sup #(
  parameter int T_RST  = 40,
  parameter int T_OSC  = 24,
  parameter int T_PBDB = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic osc_off_i,
  input  logic pin_i,
  output logic pin_pd_o,
  output logic inhibit_o
);
  localparam int LONG_HOLD = T_RST + T_OSC;
  localparam int MAX_CNT   = (LONG_HOLD > T_PBDB) ? LONG_HOLD : T_PBDB;
  localparam int CW        = $clog2(MAX_CNT + 1);
  localparam int SYNC_LAT  = 2;
  localparam logic [CW-1:0] RST_LD   = CW'(T_RST - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_HOLD - 1);
  localparam logic [CW-1:0] PBDB_LD  = CW'(T_PBDB - 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(SYNC_LAT);

  typedef enum logic [2:0] {
    IDLE, PF_ACTIVE, PF_HOLD, PB_DEBOUNCE1, PB_WAIT_RELEASE, PB_DEBOUNCE2
  } state_t;

  state_t        st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          held, held_nxt;
  logic          pin_m, pin_s, pin_prev;
  logic          pin_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pin_m, pin_s, pin_prev} <= 3'b111;
    else        {pin_m, pin_s, pin_prev} <= {pin_i, pin_m, pin_s};

  assign pin_fall = pin_prev & ~pin_s;

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt;
    held_nxt = held;
    case (st)
      IDLE:
        if (pin_fall) begin
          st_nxt  = PB_DEBOUNCE1;
          cnt_nxt = PBDB_LD;
        end
      PF_ACTIVE: begin
        st_nxt  = PF_HOLD;
        cnt_nxt = osc_off_i ? LONG_LD : RST_LD;
      end
      PF_HOLD:
        if (cnt == '0) st_nxt = IDLE;
        else           cnt_nxt = cnt - 1'b1;
      PB_DEBOUNCE1:
        if (cnt == '0) begin
          st_nxt   = PB_WAIT_RELEASE;
          cnt_nxt  = BLANK_LD;
          held_nxt = 1'b0;
        end else cnt_nxt = cnt - 1'b1;
      PB_WAIT_RELEASE:
        if (cnt != '0) cnt_nxt = cnt - 1'b1;
        else if (pin_s) begin
          st_nxt  = held ? PB_DEBOUNCE2 : IDLE;
          cnt_nxt = PBDB_LD;
        end else held_nxt = 1'b1;
      PB_DEBOUNCE2:
        if (cnt == '0) st_nxt = IDLE;
        else           cnt_nxt = cnt - 1'b1;
      default: st_nxt = PF_ACTIVE;
    endcase
    if (pwr_fail_i) st_nxt = PF_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= PF_ACTIVE;
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= cnt_nxt;
      held <= held_nxt;
    end

  assign inhibit_o = (st != IDLE);
  assign pin_pd_o  = (st != IDLE) && (st != PB_WAIT_RELEASE);
endmodule

// File: rtl/pwr_pb_reset_sup_chk.sv
module pwr_pb_reset_sup_chk #(
  parameter int T_RST  = 40,
  parameter int T_PBDB = 16
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail_i,
  input logic pin_pd_o,
  input logic inhibit_o
);
  localparam int MIN_PULSE = (T_RST < T_PBDB) ? T_RST : T_PBDB;

  int unsigned quiet, pd_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      quiet  <= 0;
      pd_run <= 0;
    end else begin
      quiet  <= pwr_fail_i ? 0 : ((quiet > T_RST) ? quiet : quiet + 1);
      pd_run <= !pin_pd_o ? 0 : ((pd_run >= MIN_PULSE) ? pd_run : pd_run + 1);
    end

  // R2
  pf_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (pin_pd_o && inhibit_o));

  // R3
  recovery_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet <= T_RST) |-> (pin_pd_o && inhibit_o));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_pd_o) |-> (pd_run >= MIN_PULSE));

  // R8
  pd_needs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pd_o |-> inhibit_o);
endmodule

bind pwr_pb_reset_sup pwr_pb_reset_sup_chk #(.T_RST(T_RST), .T_PBDB(T_PBDB)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i),
  .pin_pd_o(pin_pd_o), .inhibit_o(inhibit_o)
);

// File: tb/pwr_pb_reset_sup_tb.sv
module pwr_pb_reset_sup_tb;
  localparam int T_RST = 40, T_OSC = 24, T_PBDB = 16;

  logic clk = 1'b0, rst_n = 1'b1, pwr_fail = 1'b1, osc_off = 1'b0, btn = 1'b0;
  logic pin, pd, inh;
  int total = 0, fails = 0;

  always #5 clk = ~clk;
  assign pin = ~(pd | btn);

  pwr_pb_reset_sup #(.T_RST(T_RST), .T_OSC(T_OSC), .T_PBDB(T_PBDB)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .osc_off_i(osc_off),
    .pin_i(pin), .pin_pd_o(pd), .inhibit_o(inh)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic exp_pd, logic exp_inh);
    total++;
    if (pd !== exp_pd || inh !== exp_inh) begin
      fails++;
      $display("FAIL %s: pd/inh = %b/%b, expected %b/%b at %0t", req, pd, inh, exp_pd, exp_inh, $time);
    end
  endtask

  task automatic t_reset;
    #2 rst_n = 1'b0;
    step(3);
    chk("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_recover(logic osc);
    step(2);
    chk("R2", 1'b1, 1'b1);
    osc_off  = osc;
    pwr_fail = 1'b0;
    step(1);
    osc_off = ~osc;
    step(T_RST - 1 + (osc ? T_OSC : 0));
    chk(osc ? "R4" : "R3", 1'b1, 1'b1);
    step(1);
    chk(osc ? "R4" : "R3", 1'b0, 1'b0);
    osc_off = 1'b0;
    step(5);
  endtask

  task automatic t_fail_in_idle;
    pwr_fail = 1'b1;
    step(1);
    chk("R2", 1'b1, 1'b1);
  endtask

  task automatic press;
    btn = 1'b1;
    step(2);
    chk("R5", 1'b0, 1'b0);
    step(1);
    chk("R5", 1'b1, 1'b1);
  endtask

  task automatic t_short_press;
    press();
    step(2);
    btn = 1'b0;
    step(T_PBDB - 3);
    chk("R5", 1'b1, 1'b1);
    step(1);
    chk("R7", 1'b0, 1'b1);
    step(2);
    chk("R7", 1'b0, 1'b1);
    step(1);
    chk("R7", 1'b0, 1'b0);
    step(20);
    chk("R7", 1'b0, 1'b0);
  endtask

  task automatic t_long_press;
    press();
    step(T_PBDB);
    chk("R8", 1'b0, 1'b1);
    step(10);
    chk("R8", 1'b0, 1'b1);
    btn = 1'b0;
    step(2);
    chk("R8", 1'b0, 1'b1);
    step(1);
    chk("R8", 1'b1, 1'b1);
    step(T_PBDB - 1);
    chk("R8", 1'b1, 1'b1);
    step(1);
    chk("R8", 1'b0, 1'b0);
    step(20);
    chk("R8", 1'b0, 1'b0);
  endtask

  task automatic t_abort;
    press();
    step(3);
    btn      = 1'b0;
    pwr_fail = 1'b1;
    step(1);
    chk("R9", 1'b1, 1'b1);
    pwr_fail = 1'b0;
    step(T_RST);
    chk("R9", 1'b1, 1'b1);
    step(1);
    chk("R9", 1'b0, 1'b0);
    step(5);
  endtask

  task automatic t_press_in_hold;
    pwr_fail = 1'b1;
    step(2);
    pwr_fail = 1'b0;
    step(5);
    btn = 1'b1;
    step(T_RST - 5);
    chk("R6", 1'b1, 1'b1);
    step(1);
    chk("R6", 1'b0, 1'b0);
    step(10);
    chk("R6", 1'b0, 1'b0);
    btn = 1'b0;
    step(10);
    chk("R6", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_recover(1'b0);
    t_fail_in_idle();
    t_recover(1'b1);
    t_short_press();
    t_long_press();
    t_abort();
    t_press_in_hold();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule